// File: doc/BRIEF.md
# Clock-Enable Power-State Exit Timer

This block follows the clock-enable level that a memory controller drives to a DDR2-class device and keeps track of which low-power state the device is in: precharge power-down, active power-down or self-refresh. When the clock enable rises again, it counts out the exit delay that applies to the state being left. It gives the command scheduler one "allowed" signal for reads and one for every other command.

The exit delay depends on several things. The state entered is chosen on the edge where the clock enable falls. If a refresh command comes with that fall, the device enters self-refresh. Otherwise it enters active power-down when any bank is open and precharge power-down when none is. Leaving active power-down depends on a mode bit. In fast mode, reads wait the short power-down delay. In slow mode, reads wait a per-speed-grade base count reduced by the additive latency, and that count never drops below one clock. Leaving self-refresh holds reads for a long fixed count, while other commands wait the refresh cycle time plus a margin, rounded up to whole clocks.

The block also checks the minimum clock-enable pulse width. A change of level that comes too soon after the previous change raises a one-cycle violation flag. The block still follows the new level.

Top module: `cke_exit_timer`

## Requirements
- R1: A clock-enable transition is an edge at which the sampled `ckeIn` differs from the level sampled at the previous edge. A transition made while fewer than MIN_CKE edges (default 3), counting the previous transition's edge, have sampled the current level sets `ckeViol` to 1 for exactly the one cycle after that edge. At every other edge `ckeViol` is 0 the cycle after.
- R2: After reset the clock enable is taken as low, the state is precharge power-down, both allowed outputs are 0, `ckeViol` is 0, and the first rise does not count as a pulse-width violation.
- R3: From the edge that samples `ckeIn` low until the edge that samples it high again, `readAllowed` and `otherAllowed` are 0.
- R4: A wait of N clocks after a wake edge Tm means the output is high from just after edge Tm+N-1, so a command at edge Tm+N is legal. On exit from precharge power-down, both outputs wait PD_EXIT clocks (default 2).
- R5: On exit from active power-down with `slowExit`=0, both outputs wait PD_EXIT clocks.
- R6: On exit from active power-down with `slowExit`=1, reads wait max(SLOW_BASE - `addLat`, 1) clocks and other commands wait PD_EXIT clocks. `slowExit` and `addLat` are sampled at the wake edge.
- R7: At the falling edge, `srefEntry`=1 selects self-refresh regardless of `bankOpen`. Otherwise `bankOpen`=1 selects active power-down and `bankOpen`=0 selects precharge power-down.
- R8: On exit from self-refresh, reads wait SREF_READ clocks (default 200) and other commands wait ceil((TRFC_PS + SREF_MARGIN_PS) / CLK_PS) clocks.
- R9: Once an allowed output is high, it stays high for as long as the clock enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ckeIn | input | 1 | Clock-enable level sampled at the next edge |
| bankOpen | input | 1 | High when any bank is open |
| srefEntry | input | 1 | Decoded refresh command that accompanies a clock-enable fall |
| slowExit | input | 1 | Mode bit: 1 selects slow active power-down exit |
| addLat | input | AL_W | Additive latency in clocks |
| readAllowed | output | 1 | A read may be issued at the next edge |
| otherAllowed | output | 1 | A non-read command may be issued at the next edge |
| ckeViol | output | 1 | Pulse-width violation seen at the previous edge |

## Verification
The bench builds the block with SLOW_BASE=6 and CLK_PS=8000. This sweep of all eight additive-latency values then produces slow-exit counts that reach the one-clock floor from both exactly zero and negative raw values. With that clock period, the self-refresh non-read wait becomes a rounded-up 15 clocks, and the full 200-clock read wait stays cheap to walk edge by edge. Pulse-width changes after one, two and three held edges cover both sides of the minimum.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

  typedef enum logic [1:0] {
    PS_AWAKE   = 2'd0,
    PS_PREPD   = 2'd1,
    PS_ACTPD   = 2'd2,
    PS_SELFREF = 2'd3
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      ckeEdge;   // level differs from previous edge
    logic      wake;      // rising clock enable this edge
    pwrState_t wakeFrom;  // state being left on wake
    logic      awake;     // registered state is awake
  } pdxStrobe_t;

endpackage

// File: rtl/cke_exit_ctrl.sv
module cke_exit_ctrl
  import pdx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ckeIn,
  input  logic       bankOpen,
  input  logic       srefEntry,
  output pdxStrobe_t strobe
);

  logic      ckeQ;
  pwrState_t stateQ;
  pwrState_t stateD;
  logic      riseNow;
  logic      fallNow;

  assign riseNow = ckeIn & ~ckeQ;
  assign fallNow = ~ckeIn & ckeQ;

  always_comb begin
    stateD = stateQ;
    if (fallNow) begin
      if (srefEntry)     stateD = PS_SELFREF;
      else if (bankOpen) stateD = PS_ACTPD;
      else               stateD = PS_PREPD;
    end else if (riseNow) begin
      stateD = PS_AWAKE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckeQ   <= 1'b0;
      stateQ <= PS_PREPD;
    end else begin
      ckeQ   <= ckeIn;
      stateQ <= stateD;
    end
  end

  always_comb begin
    strobe.ckeEdge  = riseNow | fallNow;
    strobe.wake     = riseNow;
    strobe.wakeFrom = stateQ;
    strobe.awake    = (stateQ == PS_AWAKE);
  end

endmodule

// File: rtl/cke_exit_dp.sv
module cke_exit_dp
  import pdx_pkg::*;
#(
  parameter int AL_W       = 3,
  parameter int MIN_CKE    = 3,
  parameter int PD_EXIT    = 2,
  parameter int SLOW_BASE  = 8,
  parameter int SREF_READ  = 200,
  parameter int SREF_OTHER = 46
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pdxStrobe_t      strobe,
  input  logic            slowExit,
  input  logic [AL_W-1:0] addLat,
  output logic            readAllowed,
  output logic            otherAllowed,
  output logic            ckeViol
);

  localparam int MAX_A    = (SREF_READ > SREF_OTHER) ? SREF_READ : SREF_OTHER;
  localparam int MAX_B    = (SLOW_BASE > PD_EXIT) ? SLOW_BASE : PD_EXIT;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int HOLD_W   = $clog2(MIN_CKE + 1);
  localparam int N_CLASS  = 2;  // 0 = read, 1 = other

  logic [CNT_W-1:0] loadVal [N_CLASS];
  logic [CNT_W-1:0] slowVal;
  logic [N_CLASS-1:0] allowVec;
  logic [HOLD_W-1:0] holdCnt;

  // slow active power-down read count, floored at one clock
  always_comb begin
    int rawVal;
    rawVal = SLOW_BASE - int'(addLat);
    if (rawVal < 1) rawVal = 1;
    slowVal = CNT_W'(rawVal);
  end

  always_comb begin
    loadVal[0] = CNT_W'(PD_EXIT);
    loadVal[1] = CNT_W'(PD_EXIT);
    case (strobe.wakeFrom)
      PS_ACTPD:   if (slowExit) loadVal[0] = slowVal;
      PS_SELFREF: begin
        loadVal[0] = CNT_W'(SREF_READ);
        loadVal[1] = CNT_W'(SREF_OTHER);
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < N_CLASS; g++) begin : g_class
    logic [CNT_W-1:0] waitCnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 waitCnt <= '0;
      else if (strobe.wake)       waitCnt <= loadVal[g] - CNT_W'(1);
      else if (waitCnt != '0)     waitCnt <= waitCnt - CNT_W'(1);
    end
    assign allowVec[g] = strobe.awake && (waitCnt == '0);
  end

  assign readAllowed  = allowVec[0];
  assign otherAllowed = allowVec[1];

  // minimum pulse width tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdCnt <= '0;
      ckeViol <= 1'b0;
    end else begin
      ckeViol <= strobe.ckeEdge && (holdCnt != '0);
      if (strobe.ckeEdge)     holdCnt <= HOLD_W'(MIN_CKE - 1);
      else if (holdCnt != '0) holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

endmodule

// File: rtl/cke_exit_timer.sv
module cke_exit_timer
  import pdx_pkg::*;
#(
  parameter int AL_W           = 3,
  parameter int MIN_CKE        = 3,
  parameter int PD_EXIT        = 2,
  parameter int SLOW_BASE      = 8,
  parameter int SREF_READ      = 200,
  parameter int TRFC_PS        = 105000,
  parameter int SREF_MARGIN_PS = 10000,
  parameter int CLK_PS         = 2500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ckeIn,
  input  logic            bankOpen,
  input  logic            srefEntry,
  input  logic            slowExit,
  input  logic [AL_W-1:0] addLat,
  output logic            readAllowed,
  output logic            otherAllowed,
  output logic            ckeViol
);

  localparam int SREF_OTHER = (TRFC_PS + SREF_MARGIN_PS + CLK_PS - 1) / CLK_PS;

  pdxStrobe_t strobe;

  cke_exit_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ckeIn    (ckeIn),
    .bankOpen (bankOpen),
    .srefEntry(srefEntry),
    .strobe   (strobe)
  );

  cke_exit_dp #(
    .AL_W      (AL_W),
    .MIN_CKE   (MIN_CKE),
    .PD_EXIT   (PD_EXIT),
    .SLOW_BASE (SLOW_BASE),
    .SREF_READ (SREF_READ),
    .SREF_OTHER(SREF_OTHER)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .slowExit    (slowExit),
    .addLat      (addLat),
    .readAllowed (readAllowed),
    .otherAllowed(otherAllowed),
    .ckeViol     (ckeViol)
  );

endmodule

// File: rtl/cke_exit_chk.sv
module cke_exit_chk #(
  parameter int MIN_CKE = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ckeIn,
  input logic readAllowed,
  input logic otherAllowed,
  input logic ckeViol
);

  localparam int AGE_W = $clog2(MIN_CKE + 1);

  logic             ckeSeen;
  logic [AGE_W-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckeSeen <= 1'b0;
      age     <= AGE_W'(MIN_CKE);
    end else begin
      ckeSeen <= ckeIn;
      if (ckeIn != ckeSeen)          age <= AGE_W'(1);
      else if (age < AGE_W'(MIN_CKE)) age <= age + AGE_W'(1);
    end
  end

  a_r3_asleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !ckeSeen |-> (!readAllowed && !otherAllowed));

  a_r1_early_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ((ckeIn != ckeSeen) && (age < AGE_W'(MIN_CKE))) |=> ckeViol);

  a_r1_late_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((ckeIn != ckeSeen) && (age >= AGE_W'(MIN_CKE))) |=> !ckeViol);

  a_r1_steady_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ckeIn == ckeSeen) |=> !ckeViol);

  a_r9_read_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (readAllowed && ckeIn) |=> readAllowed);

  a_r9_other_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (otherAllowed && ckeIn) |=> otherAllowed);

endmodule

bind cke_exit_timer cke_exit_chk #(.MIN_CKE(MIN_CKE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ckeIn       (ckeIn),
  .readAllowed (readAllowed),
  .otherAllowed(otherAllowed),
  .ckeViol     (ckeViol)
);

// File: tb/cke_exit_timer_bench.sv
`timescale 1ns/1ps
module cke_exit_timer_bench;

  localparam int AL_W      = 3;
  localparam int SLOW_BASE = 6;
  localparam int CLK_PS    = 8000;
  localparam int PD_EXIT   = 2;
  localparam int SREF_READ = 200;
  localparam int SREF_OTH  = (105000 + 10000 + CLK_PS - 1) / CLK_PS;  // 15

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ckeIn = 1'b0;
  logic bankOpen = 1'b0;
  logic srefEntry = 1'b0;
  logic slowExit = 1'b0;
  logic [AL_W-1:0] addLat = '0;
  logic readAllowed, otherAllowed, ckeViol;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cke_exit_timer #(
    .AL_W(AL_W), .SLOW_BASE(SLOW_BASE), .CLK_PS(CLK_PS)
  ) u_cke_exit_timer (
    .clk(clk), .rst_n(rst_n), .ckeIn(ckeIn), .bankOpen(bankOpen),
    .srefEntry(srefEntry), .slowExit(slowExit), .addLat(addLat),
    .readAllowed(readAllowed), .otherAllowed(otherAllowed), .ckeViol(ckeViol)
  );

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // fall into a state; R3: outputs blocked while low
  task automatic goSleep(bit bank, bit sref);
    @(negedge clk);
    ckeIn = 1'b0; bankOpen = bank; srefEntry = sref;
    @(posedge clk);
    @(negedge clk);
    srefEntry = 1'b0; bankOpen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R3 read blocked", readAllowed, 1'b0);
      check("R3 other blocked", otherAllowed, 1'b0);
      @(negedge clk);
    end
  endtask

  // wake and walk the exit window; read waits nR, other waits nO
  task automatic wakeTimed(string req, int nR, int nO, bit slow, int al);
    int last;
    last = (nR > nO ? nR : nO) + 1;
    slowExit = slow; addLat = AL_W'(al); ckeIn = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      slowExit = 1'b0; addLat = '0;
      check({req, " read"}, readAllowed, (k >= nR - 1));
      check({req, " other"}, otherAllowed, (k >= nO - 1));
      check("R1 no violation", ckeViol, 1'b0);
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset read", readAllowed, 1'b0);
    check("R2 reset other", otherAllowed, 1'b0);
    check("R2 reset viol", ckeViol, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R2: first rise leaves precharge power-down with no violation
    wakeTimed("R2 R4 first wake", PD_EXIT, PD_EXIT, 1'b0, 0);

    goSleep(1'b0, 1'b0);
    wakeTimed("R4 prepd exit", PD_EXIT, PD_EXIT, 1'b1, 7);

    goSleep(1'b1, 1'b0);
    wakeTimed("R5 actpd fast", PD_EXIT, PD_EXIT, 1'b0, 5);

    for (int al = 0; al < 8; al++) begin
      int expR;
      expR = SLOW_BASE - al;
      if (expR < 1) expR = 1;
      goSleep(1'b1, 1'b0);
      @(negedge clk);
      wakeTimed("R6 actpd slow", expR, PD_EXIT, 1'b1, al);
    end

    // R7: refresh entry wins over open bank
    goSleep(1'b1, 1'b1);
    wakeTimed("R7 R8 sref exit", SREF_READ, SREF_OTH, 1'b1, 2);
    goSleep(1'b0, 1'b1);
    wakeTimed("R8 sref exit", SREF_READ, SREF_OTH, 1'b0, 0);

    // R1: change after one held edge
    @(negedge clk);
    ckeIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 first change ok", ckeViol, 1'b0);
    ckeIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 change after 1 edge", ckeViol, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R1 pulse one cycle", ckeViol, 1'b0);
    repeat (5) @(negedge clk);

    // R1: change after two held edges
    ckeIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    ckeIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 change after 2 edges", ckeViol, 1'b1);
    repeat (5) @(negedge clk);

    // R1: change after three held edges is legal
    ckeIn = 1'b0;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      check("R1 steady low", ckeViol, 1'b0);
    end
    ckeIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 change after 3 edges", ckeViol, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 read held", readAllowed, 1'b1);
    check("R9 other held", otherAllowed, 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule